// File: doc/BRIEF.md
# Load/Store Port Protocol Monitor

This block watches one load/store request port between a compute unit and the memory-side responder that serves it. It never drives the port. Each cycle it checks the handshake rules: how requests are issued, how long busy is held, whether the address stays stable, and the single-cycle pulses for address acknowledge, exception, load data valid and store data valid. Each broken rule sets a sticky error flag whose bit index is its error code. The monitor also latches the first error code it sees, and it counts completed loads, completed stores and reported exceptions.

A transaction starts on a cycle where exactly one request strobe is high, busy is low and no transaction is open. It then ends in one of three ways. A load ends on a cycle where load-data-valid is high and busy is low. An exception ends on a cycle where exception is high and busy is low. A store ends one cycle after an accepted store-data-valid pulse, and busy must be low on that cycle. The abort input drops whatever transaction is being tracked, without touching the error record. A programmable limit bounds how long busy may stay high.

All outputs are registered. A violation in input cycle k is visible on the outputs after the clock edge that ends cycle k.

Top module: `lsport_monitor`

## Requirements
- R1: If the load and store request strobes are high in the same cycle, error code 0 is raised and no transaction starts.
- R2: A request strobe raised while busy is high, or while a transaction is still open, raises error code 1.
- R3: Busy must be high on the first cycle after the request. Busy may then fall only on a legal ending: a load-data-valid cycle within a load, or an exception cycle. Any other fall of busy raises error code 2 and closes the transaction.
- R4: Once address-valid is seen high with busy high, address-valid must stay high and the address must stay unchanged on every later cycle that busy is high in that transaction. Otherwise error code 3 is raised.
- R5: Address acknowledge high on two consecutive cycles raises error code 4. Exception high on two consecutive cycles raises error code 5.
- R6: Exception high while busy is high raises error code 6.
- R7: Load-data-valid must be high only within a load transaction and only with busy low; otherwise error code 7 is raised. A legal load ending increments the load count, and the load data of that cycle appears on the last-load-data output.
- R8: Store-data-valid is legal only within a store transaction, with busy high, after an address acknowledge from an earlier cycle of that transaction, and only once. Any other store-data-valid pulse raises error code 8. An accepted pulse captures the store data onto the last-store-data output.
- R9: After an accepted store-data-valid, busy must be low on the very next cycle. If it is, the store count is incremented; if not, error code 9 is raised.
- R10: An address acknowledge and an exception within the same open transaction raise error code 10.
- R11: With a nonzero limit L, busy high for more than L consecutive cycles raises error code 11. A limit of zero turns this check off.
- R12: Flag bit n is sticky for code n and clears only on reset. The first cycle with any error latches the lowest code raised in that cycle, together with a valid bit, and both then hold until reset.
- R13: An abort cycle raises no error and returns the tracking to idle, so a fresh request right after it is legal. The flags, the first-error record and the counts are kept.
- R14: All counts and flags are zero after reset. Each count rises by one, one cycle after its ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| abort_i | input | 1 | Drop the tracked transaction |
| wdog_limit_i | input | WDOG_W | Busy-length limit, 0 disables |
| ld_req_i | input | 1 | Load request strobe |
| st_req_i | input | 1 | Store request strobe |
| busy_i | input | 1 | Responder busy |
| addr_vld_i | input | 1 | Address valid qualifier |
| addr_i | input | ADDR_W | Request address |
| addr_ack_i | input | 1 | Address acknowledge pulse |
| exc_i | input | 1 | Exception pulse |
| ld_vld_i | input | 1 | Load data valid pulse |
| ld_data_i | input | DATA_W | Load data |
| st_vld_i | input | 1 | Store data valid pulse |
| st_data_i | input | DATA_W | Store data |
| err_flags_o | output | 12 | Sticky error flags, bit n = code n |
| first_err_o | output | 4 | First error code seen |
| first_err_vld_o | output | 1 | First error code valid |
| ld_count_o | output | CNT_W | Completed loads |
| st_count_o | output | CNT_W | Completed stores |
| exc_count_o | output | CNT_W | Reported exceptions |
| last_ld_data_o | output | DATA_W | Data of last completed load |
| last_st_data_o | output | DATA_W | Data of last accepted store |

## Verification
Three clean sequences come first: a load, a store and a load that ends in an exception. They show that each legal ending is counted and raises no flag. A transaction cut off by an abort and followed at once by a new request shows that tracking is cleared while the record is kept. After that, every rule is broken on its own by a separate sequence, each at a different point: on the request, in the first busy cycle, in mid-transaction or on the ending. This shows which flag each violation sets and that the first code stays latched. A reference model in the bench compares every output on every cycle, so any extra or missing flag shows up in the cycle it appears.

// File: rtl/lsmon_pkg.sv
package lsmon_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_STORE = 2'd2,
        PH_TAIL  = 2'd3
    } phase_e;

    localparam int NUM_ERR = 12;
    localparam int CODE_W  = $clog2(NUM_ERR);

    localparam int ERR_BOTH_REQ  = 0;
    localparam int ERR_REQ_BUSY  = 1;
    localparam int ERR_BUSY_SEQ  = 2;
    localparam int ERR_ADDR_MOVE = 3;
    localparam int ERR_ACK_LONG  = 4;
    localparam int ERR_EXC_LONG  = 5;
    localparam int ERR_EXC_BUSY  = 6;
    localparam int ERR_LD_PULSE  = 7;
    localparam int ERR_ST_PULSE  = 8;
    localparam int ERR_ST_TAIL   = 9;
    localparam int ERR_ACK_EXC   = 10;
    localparam int ERR_WDOG      = 11;

    typedef struct packed {
        phase_e phase;
        logic   first;
        logic   ack_seen;
        logic   exc_seen;
        logic   lock;
        logic   prev_ack;
        logic   prev_exc;
    } ctl_t;

endpackage

// File: rtl/lsmon_track.sv
module lsmon_track
    import lsmon_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int WDOG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              ld_req_i,
    input  logic              st_req_i,
    input  logic              busy_i,
    input  logic              addr_vld_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              addr_ack_i,
    input  logic              exc_i,
    input  logic              ld_vld_i,
    input  logic              st_vld_i,
    output ctl_t              ctl_o,
    output logic [ADDR_W-1:0] snap_o,
    output logic [WDOG_W-1:0] wcnt_o,
    output logic              ld_done_o,
    output logic              st_take_o,
    output logic              st_done_o,
    output logic              exc_done_o
);

    typedef struct packed {
        ctl_t              ctl;
        logic [ADDR_W-1:0] snap;
        logic [WDOG_W-1:0] wcnt;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        ld_done_o  = 1'b0;
        st_take_o  = 1'b0;
        st_done_o  = 1'b0;
        exc_done_o = 1'b0;
        if (abort_i) begin
            trk_d.ctl  = '0;
            trk_d.wcnt = '0;
        end else begin
            trk_d.ctl.prev_ack = addr_ack_i;
            trk_d.ctl.prev_exc = exc_i;
            if (!busy_i) begin
                trk_d.wcnt = '0;
            end else if (trk_q.wcnt != '1) begin
                trk_d.wcnt = trk_q.wcnt + 1'b1;
            end
            unique case (trk_q.ctl.phase)
                PH_IDLE: begin
                    if ((ld_req_i ^ st_req_i) && !busy_i) begin
                        trk_d.ctl.phase    = ld_req_i ? PH_LOAD : PH_STORE;
                        trk_d.ctl.first    = 1'b1;
                        trk_d.ctl.ack_seen = 1'b0;
                        trk_d.ctl.exc_seen = 1'b0;
                        trk_d.ctl.lock     = 1'b0;
                    end
                end
                PH_LOAD, PH_STORE: begin
                    trk_d.ctl.first = 1'b0;
                    if (!busy_i) begin
                        trk_d.ctl.phase = PH_IDLE;
                        if (!trk_q.ctl.first) begin
                            if (trk_q.ctl.phase == PH_LOAD && ld_vld_i) begin
                                ld_done_o = 1'b1;
                            end else if (exc_i) begin
                                exc_done_o = 1'b1;
                            end
                        end
                    end else begin
                        if (trk_q.ctl.phase == PH_STORE && st_vld_i && trk_q.ctl.ack_seen) begin
                            trk_d.ctl.phase = PH_TAIL;
                            st_take_o       = 1'b1;
                        end
                        if (addr_ack_i) trk_d.ctl.ack_seen = 1'b1;
                        if (exc_i)      trk_d.ctl.exc_seen = 1'b1;
                        if (addr_vld_i && !trk_q.ctl.lock) begin
                            trk_d.ctl.lock = 1'b1;
                            trk_d.snap     = addr_i;
                        end
                    end
                end
                PH_TAIL: begin
                    trk_d.ctl.phase = PH_IDLE;
                    st_done_o       = !busy_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign ctl_o  = trk_q.ctl;
    assign snap_o = trk_q.snap;
    assign wcnt_o = trk_q.wcnt;

endmodule

// File: rtl/lsmon_rules.sv
module lsmon_rules
    import lsmon_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int WDOG_W = 16
) (
    input  ctl_t               ctl_i,
    input  logic [ADDR_W-1:0]  snap_i,
    input  logic [WDOG_W-1:0]  wcnt_i,
    input  logic [WDOG_W-1:0]  wdog_limit_i,
    input  logic               abort_i,
    input  logic               ld_req_i,
    input  logic               st_req_i,
    input  logic               busy_i,
    input  logic               addr_vld_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               addr_ack_i,
    input  logic               exc_i,
    input  logic               ld_vld_i,
    input  logic               st_vld_i,
    output logic [NUM_ERR-1:0] err_o
);

    logic open_q, idle_q, legal_end;

    always_comb begin
        open_q    = (ctl_i.phase == PH_LOAD) || (ctl_i.phase == PH_STORE);
        idle_q    = (ctl_i.phase == PH_IDLE);
        legal_end = ((ctl_i.phase == PH_LOAD) && ld_vld_i) || exc_i;
        err_o     = '0;
        if (!abort_i) begin
            err_o[ERR_BOTH_REQ]  = ld_req_i && st_req_i;
            err_o[ERR_REQ_BUSY]  = (ld_req_i || st_req_i) && (busy_i || !idle_q);
            err_o[ERR_BUSY_SEQ]  = open_q && !busy_i && (ctl_i.first || !legal_end);
            err_o[ERR_ADDR_MOVE] = open_q && busy_i && ctl_i.lock &&
                                   (!addr_vld_i || (addr_i != snap_i));
            err_o[ERR_ACK_LONG]  = addr_ack_i && ctl_i.prev_ack;
            err_o[ERR_EXC_LONG]  = exc_i && ctl_i.prev_exc;
            err_o[ERR_EXC_BUSY]  = exc_i && busy_i;
            err_o[ERR_LD_PULSE]  = ld_vld_i && (busy_i || (ctl_i.phase != PH_LOAD));
            err_o[ERR_ST_PULSE]  = st_vld_i && ((ctl_i.phase != PH_STORE) ||
                                   !ctl_i.ack_seen || !busy_i);
            err_o[ERR_ST_TAIL]   = (ctl_i.phase == PH_TAIL) && busy_i;
            err_o[ERR_ACK_EXC]   = open_q && ((addr_ack_i && (exc_i || ctl_i.exc_seen)) ||
                                   (exc_i && ctl_i.ack_seen));
            err_o[ERR_WDOG]      = (wdog_limit_i != '0) && busy_i && (wcnt_i >= wdog_limit_i);
        end
    end

endmodule

// File: rtl/lsmon_tally.sv
module lsmon_tally #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_done_i,
    input  logic              st_take_i,
    input  logic              st_done_i,
    input  logic              exc_done_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic [DATA_W-1:0] st_data_i,
    output logic [CNT_W-1:0]  ld_count_o,
    output logic [CNT_W-1:0]  st_count_o,
    output logic [CNT_W-1:0]  exc_count_o,
    output logic [DATA_W-1:0] last_ld_o,
    output logic [DATA_W-1:0] last_st_o
);

    typedef struct packed {
        logic [CNT_W-1:0]  n_ld;
        logic [CNT_W-1:0]  n_st;
        logic [CNT_W-1:0]  n_exc;
        logic [DATA_W-1:0] ld_dat;
        logic [DATA_W-1:0] st_dat;
    } tal_t;

    tal_t tal_d, tal_q;

    always_comb begin
        tal_d = tal_q;
        if (ld_done_i) begin
            tal_d.n_ld   = tal_q.n_ld + 1'b1;
            tal_d.ld_dat = ld_data_i;
        end
        if (st_take_i) tal_d.st_dat = st_data_i;
        if (st_done_i) tal_d.n_st  = tal_q.n_st + 1'b1;
        if (exc_done_i) tal_d.n_exc = tal_q.n_exc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tal_q <= '0;
        else        tal_q <= tal_d;
    end

    assign ld_count_o  = tal_q.n_ld;
    assign st_count_o  = tal_q.n_st;
    assign exc_count_o = tal_q.n_exc;
    assign last_ld_o   = tal_q.ld_dat;
    assign last_st_o   = tal_q.st_dat;

endmodule

// File: rtl/lsmon_errlog.sv
module lsmon_errlog
    import lsmon_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_ERR-1:0] err_i,
    output logic [NUM_ERR-1:0] flags_o,
    output logic [CODE_W-1:0]  first_o,
    output logic               first_vld_o
);

    typedef struct packed {
        logic [NUM_ERR-1:0] flags;
        logic [CODE_W-1:0]  code;
        logic               vld;
    } log_t;

    log_t log_d, log_q;

    always_comb begin
        log_d       = log_q;
        log_d.flags = log_q.flags | err_i;
        if (!log_q.vld && (err_i != '0)) begin
            log_d.vld = 1'b1;
            for (int i = NUM_ERR - 1; i >= 0; i--) begin
                if (err_i[i]) log_d.code = CODE_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) log_q <= '0;
        else        log_q <= log_d;
    end

    assign flags_o     = log_q.flags;
    assign first_o     = log_q.code;
    assign first_vld_o = log_q.vld;

endmodule

// File: rtl/lsport_monitor.sv
module lsport_monitor
    import lsmon_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 48,
    parameter int CNT_W  = 16,
    parameter int WDOG_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort_i,
    input  logic [WDOG_W-1:0]  wdog_limit_i,
    input  logic               ld_req_i,
    input  logic               st_req_i,
    input  logic               busy_i,
    input  logic               addr_vld_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               addr_ack_i,
    input  logic               exc_i,
    input  logic               ld_vld_i,
    input  logic [DATA_W-1:0]  ld_data_i,
    input  logic               st_vld_i,
    input  logic [DATA_W-1:0]  st_data_i,
    output logic [NUM_ERR-1:0] err_flags_o,
    output logic [CODE_W-1:0]  first_err_o,
    output logic               first_err_vld_o,
    output logic [CNT_W-1:0]   ld_count_o,
    output logic [CNT_W-1:0]   st_count_o,
    output logic [CNT_W-1:0]   exc_count_o,
    output logic [DATA_W-1:0]  last_ld_data_o,
    output logic [DATA_W-1:0]  last_st_data_o
);

    ctl_t               ctl;
    logic [ADDR_W-1:0]  snap;
    logic [WDOG_W-1:0]  wcnt;
    logic               ld_done, st_take, st_done, exc_done;
    logic [NUM_ERR-1:0] err;

    lsmon_track #(.ADDR_W(ADDR_W), .WDOG_W(WDOG_W)) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort_i    (abort_i),
        .ld_req_i   (ld_req_i),
        .st_req_i   (st_req_i),
        .busy_i     (busy_i),
        .addr_vld_i (addr_vld_i),
        .addr_i     (addr_i),
        .addr_ack_i (addr_ack_i),
        .exc_i      (exc_i),
        .ld_vld_i   (ld_vld_i),
        .st_vld_i   (st_vld_i),
        .ctl_o      (ctl),
        .snap_o     (snap),
        .wcnt_o     (wcnt),
        .ld_done_o  (ld_done),
        .st_take_o  (st_take),
        .st_done_o  (st_done),
        .exc_done_o (exc_done)
    );

    lsmon_rules #(.ADDR_W(ADDR_W), .WDOG_W(WDOG_W)) rules_i (
        .ctl_i        (ctl),
        .snap_i       (snap),
        .wcnt_i       (wcnt),
        .wdog_limit_i (wdog_limit_i),
        .abort_i      (abort_i),
        .ld_req_i     (ld_req_i),
        .st_req_i     (st_req_i),
        .busy_i       (busy_i),
        .addr_vld_i   (addr_vld_i),
        .addr_i       (addr_i),
        .addr_ack_i   (addr_ack_i),
        .exc_i        (exc_i),
        .ld_vld_i     (ld_vld_i),
        .st_vld_i     (st_vld_i),
        .err_o        (err)
    );

    lsmon_tally #(.DATA_W(DATA_W), .CNT_W(CNT_W)) tally_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_done_i   (ld_done),
        .st_take_i   (st_take),
        .st_done_i   (st_done),
        .exc_done_i  (exc_done),
        .ld_data_i   (ld_data_i),
        .st_data_i   (st_data_i),
        .ld_count_o  (ld_count_o),
        .st_count_o  (st_count_o),
        .exc_count_o (exc_count_o),
        .last_ld_o   (last_ld_data_o),
        .last_st_o   (last_st_data_o)
    );

    lsmon_errlog errlog_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_i       (err),
        .flags_o     (err_flags_o),
        .first_o     (first_err_o),
        .first_vld_o (first_err_vld_o)
    );

endmodule

// File: rtl/lsmon_checker.sv
module lsmon_checker #(
    parameter int NUM_ERR = 12,
    parameter int CODE_W  = 4,
    parameter int CNT_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               abort_i,
    input logic               ld_req_i,
    input logic               st_req_i,
    input logic               busy_i,
    input logic               exc_i,
    input logic               ld_vld_i,
    input logic [NUM_ERR-1:0] err_flags_o,
    input logic [CODE_W-1:0]  first_err_o,
    input logic               first_err_vld_o,
    input logic [CNT_W-1:0]   ld_count_o
);

    AST_BOTH_REQ_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req_i && st_req_i && !abort_i) |=> err_flags_o[0]); // R1

    AST_EXC_BUSY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_i && busy_i && !abort_i) |=> err_flags_o[6]); // R6

    AST_LD_BUSY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_vld_i && busy_i && !abort_i) |=> err_flags_o[7]); // R7

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((err_flags_o & $past(err_flags_o)) == $past(err_flags_o))); // R12

    AST_FIRST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        first_err_vld_o |=> (first_err_vld_o && $stable(first_err_o))); // R12

    AST_LD_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_count_o == $past(ld_count_o)) || (ld_count_o == $past(ld_count_o) + 1'b1)); // R14

endmodule

bind lsport_monitor lsmon_checker #(
    .NUM_ERR (lsmon_pkg::NUM_ERR),
    .CODE_W  (lsmon_pkg::CODE_W),
    .CNT_W   (CNT_W)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .abort_i         (abort_i),
    .ld_req_i        (ld_req_i),
    .st_req_i        (st_req_i),
    .busy_i          (busy_i),
    .exc_i           (exc_i),
    .ld_vld_i        (ld_vld_i),
    .err_flags_o     (err_flags_o),
    .first_err_o     (first_err_o),
    .first_err_vld_o (first_err_vld_o),
    .ld_count_o      (ld_count_o)
);

// File: tb/lsport_monitor_tb_top.sv
module lsport_monitor_tb_top;

    localparam int DW = 64;
    localparam int AW = 48;
    localparam int CW = 16;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          abort = 1'b0;
    logic [WW-1:0] wlim = 16'd8;
    logic          ld_req = 1'b0, st_req = 1'b0, busy = 1'b0, addr_vld = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          ack = 1'b0, exc = 1'b0, ld_vld = 1'b0, st_vld = 1'b0;
    logic [DW-1:0] ld_data = '0, st_data = '0;
    logic [11:0]   flags;
    logic [3:0]    fcode;
    logic          fvld;
    logic [CW-1:0] n_ld, n_st, n_exc;
    logic [DW-1:0] last_ld, last_st;

    always #2 clk = ~clk;

    lsport_monitor #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW), .WDOG_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .abort_i(abort), .wdog_limit_i(wlim),
        .ld_req_i(ld_req), .st_req_i(st_req), .busy_i(busy),
        .addr_vld_i(addr_vld), .addr_i(addr), .addr_ack_i(ack), .exc_i(exc),
        .ld_vld_i(ld_vld), .ld_data_i(ld_data), .st_vld_i(st_vld), .st_data_i(st_data),
        .err_flags_o(flags), .first_err_o(fcode), .first_err_vld_o(fvld),
        .ld_count_o(n_ld), .st_count_o(n_st), .exc_count_o(n_exc),
        .last_ld_data_o(last_ld), .last_st_data_o(last_st)
    );

    int n_cmp = 0;
    int n_bad = 0;

    string tag [12] = '{"R1", "R2", "R3", "R4", "R5", "R5", "R6", "R7", "R8", "R9", "R10", "R11"};

    // reference model state
    int        m_phase;   // 0 idle, 1 load, 2 store, 3 store tail
    bit        m_first, m_ackseen, m_excseen, m_lock, m_pack, m_pexc, m_fv;
    bit [AW-1:0] m_snap;
    int        m_wcnt, m_fcode, m_nld, m_nst, m_nexc;
    bit [11:0] m_flags;
    bit [DW-1:0] m_ldd, m_std;

    task automatic model_clear();
        m_phase = 0; m_first = 0; m_ackseen = 0; m_excseen = 0; m_lock = 0;
        m_pack = 0; m_pexc = 0; m_wcnt = 0;
    endtask

    task automatic model_step();
        bit [11:0] e;
        bit act, lend, f;
        int ph;
        e = '0;
        ph = m_phase;
        if (abort) begin
            model_clear();
            return;
        end
        act  = (ph == 1) || (ph == 2);
        lend = ((ph == 1) && ld_vld) || exc;
        e[0]  = ld_req && st_req;
        e[1]  = (ld_req || st_req) && (busy || ph != 0);
        e[2]  = act && !busy && (m_first || !lend);
        e[3]  = act && busy && m_lock && (!addr_vld || addr != m_snap);
        e[4]  = ack && m_pack;
        e[5]  = exc && m_pexc;
        e[6]  = exc && busy;
        e[7]  = ld_vld && (busy || ph != 1);
        e[8]  = st_vld && (ph != 2 || !m_ackseen || !busy);
        e[9]  = (ph == 3) && busy;
        e[10] = act && ((ack && (exc || m_excseen)) || (exc && m_ackseen));
        e[11] = (wlim != 0) && busy && (m_wcnt >= int'(wlim));
        if (!m_fv && e != 0) begin
            for (int i = 11; i >= 0; i--) if (e[i]) m_fcode = i;
            m_fv = 1;
        end
        m_flags |= e;
        m_pack = ack;
        m_pexc = exc;
        m_wcnt = busy ? m_wcnt + 1 : 0;
        if (ph == 0) begin
            if ((ld_req ^ st_req) && !busy) begin
                m_phase = ld_req ? 1 : 2;
                m_first = 1; m_ackseen = 0; m_excseen = 0; m_lock = 0;
            end
        end else if (ph == 3) begin
            m_phase = 0;
            if (!busy) m_nst++;
        end else begin
            f = m_first;
            m_first = 0;
            if (!busy) begin
                m_phase = 0;
                if (!f) begin
                    if (ph == 1 && ld_vld) begin m_nld++; m_ldd = ld_data; end
                    else if (exc) m_nexc++;
                end
            end else begin
                if (ph == 2 && st_vld && m_ackseen) begin m_phase = 3; m_std = st_data; end
                if (ack) m_ackseen = 1;
                if (exc) m_excseen = 1;
                if (addr_vld && !m_lock) begin m_lock = 1; m_snap = addr; end
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            model_clear();
            m_flags = '0; m_fv = 0; m_fcode = 0; m_nld = 0; m_nst = 0; m_nexc = 0;
            m_ldd = '0; m_std = '0; m_snap = '0;
        end else begin
            model_step();
        end
    end

    task automatic chk(string req, string what, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (flags != m_flags) begin
                string s;
                s = "";
                n_bad++;
                for (int i = 0; i < 12; i++) if (flags[i] != m_flags[i]) s = {s, tag[i], " "};
                $display("FAIL %sflags actual=%0h expected=%0h", s, flags, m_flags);
            end
            chk("R12", "first code", {fvld, fcode}, {m_fv, 4'(m_fcode)});
            chk("R14", "load count", n_ld, CW'(m_nld));
            chk("R14", "store count", n_st, CW'(m_nst));
            chk("R14", "exception count", n_exc, CW'(m_nexc));
            chk("R7", "last load data", last_ld, m_ldd);
            chk("R8", "last store data", last_st, m_std);
        end
    end

    task automatic cy(bit l, bit s, bit b, bit av, bit ak, bit ex, bit lv, bit sv);
        ld_req = l; st_req = s; busy = b; addr_vld = av;
        ack = ak; exc = ex; ld_vld = lv; st_vld = sv;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cy(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R14", "reset load count", n_ld, 0);
        chk("R12", "reset flags", flags, 0);
        // legal load
        addr = 48'h100; ld_data = 64'hAA55;
        cy(1,0,0,0,0,0,0,0); cy(0,0,1,1,0,0,0,0); cy(0,0,1,1,1,0,0,0);
        cy(0,0,1,1,0,0,0,0); cy(0,0,0,1,0,0,1,0); idle(1);
        chk("R7", "load counted", n_ld, 1);
        chk("R7", "load data", last_ld, 64'hAA55);
        // legal store
        addr = 48'h208; st_data = 64'h1234;
        cy(0,1,0,0,0,0,0,0); cy(0,0,1,1,0,0,0,0); cy(0,0,1,1,1,0,0,0);
        cy(0,0,1,1,0,0,0,1); cy(0,0,0,0,0,0,0,0); idle(1);
        chk("R9", "store counted", n_st, 1);
        chk("R8", "store data", last_st, 64'h1234);
        // load ending in exception
        cy(1,0,0,0,0,0,0,0); cy(0,0,1,1,0,0,0,0); cy(0,0,0,0,0,1,0,0); idle(1);
        chk("R14", "exception counted", n_exc, 1);
        // abort mid-load, then an immediate new store
        cy(1,0,0,0,0,0,0,0); cy(0,0,1,1,0,0,0,0);
        abort = 1'b1; cy(0,0,0,0,0,0,0,0); abort = 1'b0;
        cy(0,1,0,0,0,0,0,0); cy(0,0,1,1,1,0,0,0); cy(0,0,1,1,0,0,0,1);
        cy(0,0,0,0,0,0,0,0); idle(1);
        chk("R13", "no error after abort", flags, 0);
        chk("R13", "store after abort", n_st, 2);
        // R1 both requests
        cy(1,1,0,0,0,0,0,0); idle(1);
        chk("R1", "both-request flag", flags[0], 1);
        chk("R12", "first code", {fvld, fcode}, 5'h10);
        // R2 request while busy
        cy(1,0,0,0,0,0,0,0); cy(0,0,1,1,0,0,0,0); cy(0,1,1,1,0,0,0,0);
        cy(0,0,0,1,0,0,1,0); idle(1);
        chk("R2", "request-while-busy flag", flags[1], 1);
        // R3 busy not raised
        cy(1,0,0,0,0,0,0,0); cy(0,0,0,0,0,0,0,0); idle(1);
        chk("R3", "busy sequence flag", flags[2], 1);
        // R4 address moves
        addr = 48'h300;
        cy(0,1,0,0,0,0,0,0); cy(0,0,1,1,0,0,0,0);
        addr = 48'h308; cy(0,0,1,1,0,0,0,0);
        abort = 1'b1; cy(0,0,0,0,0,0,0,0); abort = 1'b0; idle(1);
        chk("R4", "address flag", flags[3], 1);
        // R5 acknowledge held two cycles
        cy(1,0,0,0,0,0,0,0); cy(0,0,1,1,1,0,0,0); cy(0,0,1,1,1,0,0,0);
        cy(0,0,0,1,0,0,1,0); idle(1);
        chk("R5", "long ack flag", flags[4], 1);
        // R6 exception with busy high
        cy(1,0,0,0,0,0,0,0); cy(0,0,1,1,0,0,0,0); cy(0,0,1,1,0,1,0,0);
        cy(0,0,0,1,0,0,1,0); idle(1);
        chk("R6", "exception-busy flag", flags[6], 1);
        // R5 exception held two cycles
        cy(1,0,0,0,0,0,0,0); cy(0,0,1,1,0,0,0,0); cy(0,0,0,0,0,1,0,0);
        cy(0,0,0,0,0,1,0,0); idle(1);
        chk("R5", "long exception flag", flags[5], 1);
        // R7 load valid with busy high
        cy(1,0,0,0,0,0,0,0); cy(0,0,1,1,0,0,0,0); cy(0,0,1,1,0,0,1,0);
        cy(0,0,0,1,0,0,1,0); idle(1);
        chk("R7", "load pulse flag", flags[7], 1);
        // R8 store data before acknowledge
        cy(0,1,0,0,0,0,0,0); cy(0,0,1,1,0,0,0,0); cy(0,0,1,1,0,0,0,1);
        abort = 1'b1; cy(0,0,0,0,0,0,0,0); abort = 1'b0; idle(1);
        chk("R8", "early store flag", flags[8], 1);
        // R9 busy held after store data
        cy(0,1,0,0,0,0,0,0); cy(0,0,1,1,1,0,0,0); cy(0,0,1,1,0,0,0,1);
        cy(0,0,1,1,0,0,0,0); idle(2);
        chk("R9", "store release flag", flags[9], 1);
        // R10 acknowledge then exception
        cy(1,0,0,0,0,0,0,0); cy(0,0,1,1,1,0,0,0); cy(0,0,0,0,0,1,0,0); idle(1);
        chk("R10", "ack and exception flag", flags[10], 1);
        // R11 busy too long
        cy(1,0,0,0,0,0,0,0);
        for (int i = 0; i < 10; i++) cy(0,0,1,1,0,0,0,0);
        cy(0,0,0,1,0,0,1,0); idle(1);
        chk("R11", "watchdog flag", flags[11], 1);
        // R13 abort leaves the record in place
        abort = 1'b1; cy(0,0,0,0,0,0,0,0); abort = 1'b0; idle(1);
        chk("R13", "flags kept over abort", flags, 12'hFFF);
        chk("R12", "first code kept", {fvld, fcode}, 5'h10);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL R12 watchdog actual=running expected=finished");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule